// File: doc/BRIEF.md
# Three-Stage Decimating Filter Chain

This block turns an oversampled stream of signed samples into a slower stream of 24-bit two's complement words. Each input sample arrives with a one-clock enable. Three stages run in series. A seventh-order sinc decimator reduces the rate by 2·n, where n is 1, 2 or 4 and set by a parameter. Two symmetric FIR stages follow, and each of them halves the rate again. The overall ratio is 8, 16 or 32.

The two FIR stages take their coefficient sets and normalising shifts from parameter arrays. With the default sets the FIR gain at DC is exactly one, so a constant input x settles to x·(2n)^7 at the output. The final value is clamped to the 24-bit range. A synchronous filter reset clears every integrator, comb delay, tap and phase counter. After a reset, a settling count hides a parameterised number of early results so that half-settled words never appear. The output strobe is one clock wide.

Top module: `decim_chain`

## Requirements
- R1: While the filter reset is high, and in the first cycle after it falls, `out_valid` is 0 and `out_data` is 0.
- R2: After settling, exactly 8·n enabled input samples separate two consecutive output strobes.
- R3: `out_valid` is never high in two consecutive clock cycles.
- R4: A constant input x held long enough settles to an output of exactly x·(2n)^7. With the default n=1 this is x·128.
- R5: A result above +8388607 is output as +8388607, and a result below −8388608 is output as −8388608. The input is 18-bit signed.
- R6: After a reset, the first SETTLE_OUT final-stage results are withheld. The first strobe follows input sample number 8·n·(SETTLE_OUT+1), which is 600 with the defaults (n=1, SETTLE_OUT=74).
- R7: A reset applied during operation clears all state. The next first-strobe position is again as in R6, and its value for zero input is 0 even after large earlier inputs.
- R8: The value on `in_data` has no effect while `in_en` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous active-high filter reset |
| in_en | input | 1 | Qualifies `in_data` as one oversampled sample |
| in_data | input | IN_W (18) | Signed oversampled sample |
| out_valid | output | 1 | One-cycle strobe for each output word |
| out_data | output | 24 | Saturated two's complement output word |

## Verification
The hardest case to reach from the ports is the exact sample on which the first valid word appears after a reset. To reach it, the settling counter, the sinc phase counter and both FIR phase flags must all restart together. The bench spaces the input enables widely enough that every strobe lands before the next enable, and counts enables from the reset. It then repeats that count after a reset issued in the middle of a full-scale run. Saturation is reached by holding extreme constant inputs, whose gain-scaled value crosses the 24-bit limit. Random data is driven whenever the enable is low, which shows that the exact DC results do not depend on it.

// File: rtl/dfc_pkg.sv
package dfc_pkg;
  localparam int SINC_ORDER = 7;
  localparam int WORD_W     = 24;
  localparam int COEF_W     = 18;
endpackage

// File: rtl/dfc_sinc.sv
module dfc_sinc #(
  parameter int IN_W  = 18,
  parameter int RATIO = 2,
  parameter int ORDER = dfc_pkg::SINC_ORDER,
  localparam int CW   = (RATIO > 2) ? $clog2(RATIO) : 1,
  localparam int W    = IN_W + ORDER * $clog2(RATIO)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                in_en,
  input  logic signed [IN_W-1:0] in_data,
  output logic                out_v,
  output logic signed [W-1:0] out_data
);
  logic signed [W-1:0] integ [ORDER];
  logic signed [W-1:0] dly   [ORDER];
  logic signed [W-1:0] cs    [ORDER+1];
  logic [CW-1:0]       ph;
  logic                dec;

  for (genvar k = 0; k < ORDER; k++) begin : g_int
    if (k == 0) begin : g_first
      always_ff @(posedge clk)
        if (rst) integ[k] <= '0;
        else if (in_en) integ[k] <= integ[k] + W'(in_data);
    end else begin : g_rest
      always_ff @(posedge clk)
        if (rst) integ[k] <= '0;
        else if (in_en) integ[k] <= integ[k] + integ[k-1];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ph  <= '0;
      dec <= 1'b0;
    end else begin
      dec <= in_en && (ph == CW'(RATIO - 1));
      if (in_en) ph <= (ph == CW'(RATIO - 1)) ? '0 : ph + 1'b1;
    end
  end

  always_comb begin
    cs[0] = integ[ORDER-1];
    for (int k = 0; k < ORDER; k++) cs[k+1] = cs[k] - dly[k];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < ORDER; k++) dly[k] <= '0;
      out_data <= '0;
      out_v    <= 1'b0;
    end else begin
      out_v <= dec;
      if (dec) begin
        for (int k = 0; k < ORDER; k++) dly[k] <= cs[k];
        out_data <= cs[ORDER];
      end
    end
  end

  // R2: the sinc stage emits at most one word per RATIO (>=2) enabled samples
  assert_sinc_gap_R2: assert property (@(posedge clk) disable iff (rst)
    out_v |=> !out_v);
endmodule

// File: rtl/dfc_fir2.sv
module dfc_fir2 #(
  parameter int IN_W  = 25,
  parameter int TAPS  = 7,
  parameter int COEF [TAPS] = '{-1, 0, 9, 16, 9, 0, -1},
  parameter int SHIFT = 5,
  localparam int OW   = IN_W + 1,
  localparam int AW   = IN_W + 2 + dfc_pkg::COEF_W + $clog2(TAPS)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 in_v,
  input  logic signed [IN_W-1:0] in_d,
  output logic                 out_v,
  output logic signed [OW-1:0] out_d
);
  logic signed [IN_W-1:0] tap [TAPS];
  logic signed [AW-1:0]   acc, cw, pair;
  logic                   phase, fire;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < TAPS; k++) tap[k] <= '0;
      phase <= 1'b0;
      fire  <= 1'b0;
    end else begin
      fire <= in_v && phase;
      if (in_v) begin
        tap[0] <= in_d;
        for (int k = 1; k < TAPS; k++) tap[k] <= tap[k-1];
        phase <= ~phase;
      end
    end
  end

  always_comb begin
    acc = '0;
    for (int k = 0; k < TAPS / 2; k++) begin
      cw   = AW'(COEF[k]);
      pair = AW'(tap[k]) + AW'(tap[TAPS-1-k]);
      acc  = acc + cw * pair;
    end
    cw   = AW'(COEF[TAPS/2]);
    pair = (TAPS % 2 == 1) ? AW'(tap[TAPS/2]) : '0;
    acc  = acc + cw * pair;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_v <= 1'b0;
      out_d <= '0;
    end else begin
      out_v <= fire;
      if (fire) out_d <= OW'(acc >>> SHIFT);
    end
  end

  // R2: each FIR word is the result of an accepted input two cycles earlier
  assert_fir_follows_R2: assert property (@(posedge clk) disable iff (rst)
    out_v |-> $past(in_v, 2));
endmodule

// File: rtl/decim_chain.sv
module decim_chain #(
  parameter int IN_W       = 18,
  parameter int MODEL_N    = 1,
  parameter int SETTLE_OUT = 74,
  parameter int F1_TAPS    = 7,
  parameter int F1_COEF [F1_TAPS] = '{-1, 0, 9, 16, 9, 0, -1},
  parameter int F1_SHIFT   = 5,
  parameter int F2_TAPS    = 7,
  parameter int F2_COEF [F2_TAPS] = '{-3, 0, 19, 32, 19, 0, -3},
  parameter int F2_SHIFT   = 6
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  in_en,
  input  logic signed [IN_W-1:0] in_data,
  output logic                  out_valid,
  output logic signed [23:0]    out_data
);
  localparam int OUT_W = dfc_pkg::WORD_W;
  localparam int RATIO = 2 * MODEL_N;
  localparam int SW    = IN_W + dfc_pkg::SINC_ORDER * $clog2(RATIO);
  localparam int F1W   = SW + 1;
  localparam int F2W   = F1W + 1;
  localparam int EW    = ((F2W > OUT_W) ? F2W : OUT_W) + 1;
  localparam int SCW   = $clog2(SETTLE_OUT + 2);
  localparam logic signed [EW-1:0] SMAX = EW'((64'sd1 <<< (OUT_W - 1)) - 1);
  localparam logic signed [EW-1:0] SMIN = -SMAX - 1;

  logic                  s_v, f1_v, f2_v;
  logic signed [SW-1:0]  s_d;
  logic signed [F1W-1:0] f1_d;
  logic signed [F2W-1:0] f2_d;
  logic signed [EW-1:0]  ext;
  logic [SCW-1:0]        settle;

  dfc_sinc #(.IN_W(IN_W), .RATIO(RATIO)) u_sinc (
    .clk(clk), .rst(rst), .in_en(in_en), .in_data(in_data),
    .out_v(s_v), .out_data(s_d));

  dfc_fir2 #(.IN_W(SW), .TAPS(F1_TAPS), .COEF(F1_COEF), .SHIFT(F1_SHIFT)) u_fir_a (
    .clk(clk), .rst(rst), .in_v(s_v), .in_d(s_d), .out_v(f1_v), .out_d(f1_d));

  dfc_fir2 #(.IN_W(F1W), .TAPS(F2_TAPS), .COEF(F2_COEF), .SHIFT(F2_SHIFT)) u_fir_b (
    .clk(clk), .rst(rst), .in_v(f1_v), .in_d(f1_d), .out_v(f2_v), .out_d(f2_d));

  assign ext = EW'(f2_d);

  always_ff @(posedge clk) begin
    if (rst) begin
      settle    <= '0;
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= 1'b0;
      if (f2_v) begin
        if (settle < SCW'(SETTLE_OUT)) begin
          settle <= settle + 1'b1;
        end else begin
          out_valid <= 1'b1;
          if (ext > SMAX)      out_data <= OUT_W'(SMAX);
          else if (ext < SMIN) out_data <= OUT_W'(SMIN);
          else                 out_data <= OUT_W'(ext);
        end
      end
    end
  end

  // R1: nothing is presented in the first cycle after reset
  assert_reset_clear_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!out_valid && out_data == '0));
  // R3: single-cycle strobe
  assert_valid_pulse_R3: assert property (@(posedge clk) disable iff (rst)
    out_valid |=> !out_valid);
  // R6: every strobe stems from a final-stage result of the previous cycle
  assert_valid_source_R6: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> $past(f2_v));
endmodule

// File: tb/sim_decim_chain.sv
module sim_decim_chain;
  localparam int N      = 1;
  localparam int SETTLE = 74;
  localparam int DEC    = 8 * N;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_en = 1'b0;
  logic signed [17:0] in_data = '0;
  logic out_valid;
  logic signed [23:0] out_data;

  int checks = 0, fails = 0;
  int samples = 0, last_strobe = 0, n_strobes = 0;
  bit prev_valid = 1'b0;
  logic signed [23:0] last_data = '0;

  always #5 clk = ~clk;

  decim_chain u0 (.clk(clk), .rst(rst), .in_en(in_en), .in_data(in_data),
                  .out_valid(out_valid), .out_data(out_data));

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // monitor: strobe width (R3) and spacing (R2)
  always @(negedge clk) begin
    if (!rst) begin
      if (out_valid && prev_valid) check(1'b0, "R3 strobe width", 2, 1);
      if (out_valid) begin
        if (n_strobes > 0) check(samples - last_strobe == DEC, "R2 strobe spacing",
                                 samples - last_strobe, DEC);
        n_strobes++;
        last_strobe = samples;
        last_data = out_data;
      end
    end
    prev_valid = out_valid;
  end

  task automatic push(input logic signed [17:0] v);
    @(negedge clk);
    in_en = 1'b1; in_data = v; samples++;
    @(negedge clk);
    in_en = 1'b0; in_data = 18'($urandom);  // R8: junk while disabled
    repeat (8) @(negedge clk);
  endtask

  task automatic push_until(input logic signed [17:0] v, input int k);
    int target = n_strobes + k;
    while (n_strobes < target) push(v);
  endtask

  task automatic t_reset;
    @(negedge clk); rst = 1'b1; in_en = 1'b0;
    repeat (3) @(negedge clk);
    check(out_valid == 1'b0, "R1 valid in reset", out_valid, 0);
    rst = 1'b0;
    samples = 0; n_strobes = 0; last_strobe = 0;
    @(negedge clk);
    check(out_valid == 1'b0 && out_data == 0, "R1 state after reset", out_data, 0);
  endtask

  task automatic t_settle(input string req);
    push_until(18'sd0, 1);
    check(last_strobe == DEC * (SETTLE + 1), {req, " first strobe sample"},
          last_strobe, DEC * (SETTLE + 1));
    check(last_data == 0, {req, " first word for zero input"}, last_data, 0);
  endtask

  task automatic t_dc(input logic signed [17:0] x, input longint exp, input string req);
    push_until(x, 40);
    for (int i = 0; i < 3; i++) begin
      push_until(x, 1);
      check(longint'(last_data) == exp, req, last_data, exp);
    end
  endtask

  initial begin
    t_reset();
    t_settle("R6");
    t_dc(18'sd1000, 128000, "R4 R8 positive DC");
    t_dc(-18'sd2500, -320000, "R4 R8 negative DC");
    t_dc(18'sd131071, 8388607, "R5 positive clamp");
    t_dc(-18'sd131072, -8388608, "R5 negative clamp");
    t_reset();
    t_settle("R7");
    check(n_strobes == 1, "R2 strobe count after reset", n_strobes, 1);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    check(1'b0, "watchdog", 0, 1);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule